// File: doc/BRIEF.md
# Address-Masked GPIO Port

An eight-pin general purpose I/O port attached to a simple APB-style register bus with byte-wide data. Software selects, per pin, whether the port drives the pad or listens to it, and moves pin values through a data window. The address of a window access doubles as a per-pin select mask. A single bus write can therefore update any subset of the output pins without a read-modify-write sequence. A window read likewise returns only the pins the address names.

Pad inputs cross into the bus clock domain through a two-stage synchronizer. The synchronized levels are used by the read path and are also exported to a separate edge or level detection block. Output enables follow the direction register directly. Every transfer completes in one access phase with no wait states.

Top module: `gpio_mask_port`

## Requirements
- R1: After synchronous reset, every pin is an input: pad_oe is 0x00, the output register is 0x00 so pad_out is 0x00, and a read of the direction register returns 0x00.
- R2: The direction register lives at offset 0x400. Bit n set to 1 makes pin n an output and 0 makes it an input. pad_oe equals this register, and a read at 0x400 returns it.
- R3: Offsets with paddr[10]=0 form the data window. The mask is paddr[9:2], so pin n alone sits at offset 1<<(n+2). A window write changes only the output bits whose mask bit is 1.
- R4: A window write leaves a pin's output bit unchanged while that pin is an input, even if its mask bit is 1. After the pin is switched to output, it keeps its old value until it is written again.
- R5: A window read returns 0 in every bit whose mask bit is 0.
- R6: In a window read, a masked-in output pin returns its driven output value, and a masked-in input pin returns its synchronized pad level.
- R7: pin_sync follows pad_in through exactly two flops. A pad change made between edges appears on pin_sync after the second rising edge.
- R8: Offsets with paddr[10]=1 other than 0x400 are void. Writes to them change nothing, and reads return 0x00.
- R9: A write takes effect only at a rising edge where psel, penable and pwrite are all 1. A setup phase alone, or penable without psel, changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 11 | Byte offset of the access |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid during the access phase |
| pad_in | input | 8 | Raw pad levels, asynchronous |
| pad_out | output | 8 | Output register driven toward the pads |
| pad_oe | output | 8 | Per-pin output enable |
| pin_sync | output | 8 | Synchronized pad levels for detection logic |

## Verification
A window read and a pad transition can fall in the same cycle. The read then returns the level held by the second synchronizer flop, not the new pad level. The bench changes pad_in on a falling edge and samples pin_sync after one and after two rising edges, expecting the old value and then the new one. It then reads the window with a mixed direction setting and checks that output pins return the register value while input pins return the new synchronized level. A second overlap occurs when a window write aims at pins that are still inputs in the same configuration where others are outputs. Here the bench compares pad_out against a value built only from the output-enabled, masked-in bits.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_PINS  = 8;
    localparam int MASK_LSB   = 2;
    localparam int ADDR_W     = PORT_PINS + MASK_LSB + 1;
    localparam int SYNC_DEPTH = 2;
    localparam logic [ADDR_W-1:0] DIR_OFFSET = ADDR_W'(1) << (PORT_PINS + MASK_LSB);

    typedef logic [PORT_PINS-1:0] pins_t;
    typedef logic [ADDR_W-1:0]    addr_t;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_DATA = 2'd1,
        ACC_DIR  = 2'd2,
        ACC_VOID = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e  kind;
        logic  wr;
        pins_t mask;
        pins_t wdata;
    } bus_req_t;

    function automatic acc_e classify(addr_t a);
        if (!a[ADDR_W-1])
            return ACC_DATA;
        else if (a == DIR_OFFSET)
            return ACC_DIR;
        else
            return ACC_VOID;
    endfunction

    function automatic pins_t window_mask(addr_t a);
        return a[MASK_LSB +: PORT_PINS];
    endfunction

    function automatic pins_t pin_level(pins_t dir, pins_t drv, pins_t smp);
        return (dir & drv) | (~dir & smp);
    endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
    import gpio_port_pkg::*;
(
    input  logic     psel,
    input  logic     penable,
    input  logic     pwrite,
    input  addr_t    paddr,
    input  pins_t    pwdata,
    output bus_req_t req
);
    always_comb begin
        req.kind  = ACC_IDLE;
        req.wr    = 1'b0;
        req.mask  = '0;
        req.wdata = pwdata;
        if (psel && penable) begin
            req.kind = classify(paddr);
            req.wr   = pwrite;
            req.mask = window_mask(paddr);
        end
    end
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
    import gpio_port_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bus_req_t req,
    output pins_t    dir_q,
    output pins_t    out_q
);
    logic dir_we;
    logic dat_we;

    assign dir_we = req.wr && (req.kind == ACC_DIR);
    assign dat_we = req.wr && (req.kind == ACC_DATA);

    for (genvar i = 0; i < PORT_PINS; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst)
                dir_q[i] <= 1'b0;
            else if (dir_we)
                dir_q[i] <= req.wdata[i];
        end

        always_ff @(posedge clk) begin
            if (rst)
                out_q[i] <= 1'b0;
            else if (dat_we && req.mask[i] && dir_q[i])
                out_q[i] <= req.wdata[i];
        end
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync
    import gpio_port_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
)(
    input  logic  clk,
    input  logic  rst,
    input  pins_t pad_in,
    output pins_t sync_q
);
    pins_t stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= pad_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[s] <= '0;
                else     stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_port_pkg::*;
(
    input  bus_req_t req,
    input  pins_t    dir_q,
    input  pins_t    out_q,
    input  pins_t    sync_q,
    output pins_t    rdata
);
    always_comb begin
        rdata = '0;
        if (!req.wr) begin
            unique case (req.kind)
                ACC_DATA: rdata = pin_level(dir_q, out_q, sync_q) & req.mask;
                ACC_DIR:  rdata = dir_q;
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port
    import gpio_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        psel,
    input  logic        penable,
    input  logic        pwrite,
    input  logic [10:0] paddr,
    input  logic [7:0]  pwdata,
    output logic [7:0]  prdata,
    input  logic [7:0]  pad_in,
    output logic [7:0]  pad_out,
    output logic [7:0]  pad_oe,
    output logic [7:0]  pin_sync
);
    bus_req_t req;
    pins_t    dir_q;
    pins_t    out_q;
    pins_t    sync_q;

    gpio_bus_decode u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .req     (req)
    );

    gpio_pin_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .dir_q (dir_q),
        .out_q (out_q)
    );

    gpio_in_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pad_in (pad_in),
        .sync_q (sync_q)
    );

    gpio_read_mux u_rmux (
        .req    (req),
        .dir_q  (dir_q),
        .out_q  (out_q),
        .sync_q (sync_q),
        .rdata  (prdata)
    );

    assign pad_out  = out_q;
    assign pad_oe   = dir_q;
    assign pin_sync = sync_q;
endmodule

// File: rtl/gpio_mask_port_chk.sv
module gpio_mask_port_chk (
    input logic        clk,
    input logic        rst,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [10:0] paddr,
    input logic [7:0]  pwdata,
    input logic [7:0]  prdata,
    input logic [7:0]  pad_in,
    input logic [7:0]  pad_out,
    input logic [7:0]  pad_oe,
    input logic [7:0]  pin_sync
);
    logic       past_rst;
    logic [1:0] cyc;
    logic       acc, win_wr, dir_wr, win_rd, any_wr;

    assign acc    = psel && penable;
    assign any_wr = acc && pwrite;
    assign win_wr = any_wr && !paddr[10];
    assign dir_wr = any_wr && (paddr == 11'h400);
    assign win_rd = acc && !pwrite && !paddr[10];

    always_ff @(posedge clk) begin
        past_rst <= rst;
        if (rst)          cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    a_r1_reset_values: assert property (@(posedge clk)
        past_rst |-> (pad_oe == 8'h00 && pad_out == 8'h00));

    a_r2_oe_follows_dir: assert property (@(posedge clk) disable iff (rst)
        dir_wr |=> (pad_oe == $past(pwdata)));

    a_r3_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
        win_wr |=> (((pad_out ^ $past(pad_out)) & ~$past(paddr[9:2])) == 8'h00));

    a_r4_input_hold: assert property (@(posedge clk) disable iff (rst)
        win_wr |=> (((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == 8'h00));

    a_r5_read_mask: assert property (@(posedge clk) disable iff (rst)
        win_rd |-> ((prdata & ~paddr[9:2]) == 8'h00));

    a_r7_two_stage: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2) |-> (pin_sync == $past(pad_in, 2)));

    a_r9_no_write_hold: assert property (@(posedge clk) disable iff (rst)
        !win_wr |=> $stable(pad_out));

    a_r9_dir_hold: assert property (@(posedge clk) disable iff (rst)
        !dir_wr |=> $stable(pad_oe));
endmodule

bind gpio_mask_port gpio_mask_port_chk u_chk (.*);

// File: tb/sim_gpio_mask_port.sv
`timescale 1ns/1ps
module sim_gpio_mask_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [10:0] paddr = '0;
    logic [7:0]  pwdata = '0;
    logic [7:0]  prdata;
    logic [7:0]  pad_in = '0;
    logic [7:0]  pad_out, pad_oe, pin_sync;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_mask_port u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pin_sync(pin_sync)
    );

    typedef struct packed {
        logic        wr;
        logic [10:0] addr;
        logic [7:0]  wd;
        logic [7:0]  rd_exp;
        logic [7:0]  out_exp;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 11'h400, 8'h0F, 8'h00, 8'h00, 4'd2},  // R2 low nibble outputs
        '{1'b0, 11'h400, 8'h00, 8'h0F, 8'h00, 4'd2},
        '{1'b1, 11'h3FC, 8'hFF, 8'h00, 8'h0F, 4'd4},  // R4 inputs ignore write
        '{1'b0, 11'h3FC, 8'h00, 8'h0F, 8'h0F, 4'd6},  // R6 mixed read
        '{1'b1, 11'h004, 8'h00, 8'h00, 8'h0E, 4'd3},  // R3 pin 0 only
        '{1'b0, 11'h3FC, 8'h00, 8'h0E, 8'h0E, 4'd3},
        '{1'b0, 11'h008, 8'h00, 8'h02, 8'h0E, 4'd5},  // R5 pin 1 only
        '{1'b0, 11'h004, 8'h00, 8'h00, 8'h0E, 4'd5},
        '{1'b1, 11'h030, 8'h04, 8'h00, 8'h06, 4'd3},  // pins 2,3
        '{1'b0, 11'h3FC, 8'h00, 8'h06, 8'h06, 4'd3},
        '{1'b1, 11'h400, 8'hFF, 8'h00, 8'h06, 4'd4},  // switch all to output
        '{1'b0, 11'h3FC, 8'h00, 8'h06, 8'h06, 4'd4},
        '{1'b1, 11'h3C0, 8'hA0, 8'h00, 8'hA6, 4'd3},  // upper nibble
        '{1'b0, 11'h3FC, 8'h00, 8'hA6, 8'hA6, 4'd6},
        '{1'b0, 11'h300, 8'h00, 8'h80, 8'hA6, 4'd5},  // mask 0xC0
        '{1'b1, 11'h404, 8'h00, 8'h00, 8'hA6, 4'd8},  // R8 void write
        '{1'b0, 11'h404, 8'h00, 8'h00, 8'hA6, 4'd8},
        '{1'b0, 11'h400, 8'h00, 8'hFF, 8'hA6, 4'd2}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1;
        @(negedge clk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic bus_read(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge clk); penable = 1;
        #1 d = prdata;
        @(negedge clk); psel = 0; penable = 0;
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 pin_sync", pin_sync, 8'h00);
        bus_read(11'h400, rd); check("R1 dir read", rd, 8'h00);
        bus_read(11'h3FC, rd); check("R1 window read", rd, 8'h00);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i].wr) bus_write(VEC[i].addr, VEC[i].wd);
            else begin
                bus_read(VEC[i].addr, rd);
                check($sformatf("R%0d read vec %0d", VEC[i].rq, i), rd, VEC[i].rd_exp);
            end
            check($sformatf("R%0d pad_out vec %0d", VEC[i].rq, i), pad_out, VEC[i].out_exp);
        end
        check("R2 pad_oe all out", pad_oe, 8'hFF);

        // R7 synchronizer latency, R6 mixed read
        bus_write(11'h400, 8'h0F);
        check("R2 pad_oe nibble", pad_oe, 8'h0F);
        @(negedge clk); pad_in = 8'h5A;
        @(negedge clk); check("R7 after one edge", pin_sync, 8'h00);
        @(negedge clk); check("R7 after two edges", pin_sync, 8'h5A);
        bus_read(11'h3FC, rd); check("R6 mixed levels", rd, 8'h56);
        bus_read(11'h3C0, rd); check("R5 upper mask", rd, 8'h50);

        // R4 rewrite after switch: upper keeps old A, lower written
        bus_write(11'h3FC, 8'hFF);
        check("R4 partial update", pad_out, 8'hAF);

        // R9 setup phase only, then penable without psel
        @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 11'h3FC; pwdata = 8'h00;
        @(negedge clk); psel = 0; pwrite = 0;
        @(negedge clk); check("R9 setup only", pad_out, 8'hAF);
        psel = 0; penable = 1; pwrite = 1; paddr = 11'h400; pwdata = 8'hFF;
        @(negedge clk); penable = 0; pwrite = 0;
        @(negedge clk);
        check("R9 no psel data", pad_out, 8'hAF);
        check("R9 no psel dir", pad_oe, 8'h0F);

        // R1 reset in mid-run
        rst = 1;
        repeat (2) @(negedge clk);
        check("R1 mid oe", pad_oe, 8'h00);
        check("R1 mid out", pad_out, 8'h00);
        check("R1 mid sync", pin_sync, 8'h00);
        rst = 0;
        bus_read(11'h400, rd); check("R1 mid dir read", rd, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule